// File: doc/BRIEF.md
# Bit-Serial SIMD Mesh Processor Array

This block is a rectangular grid of one-bit processing elements that all execute the same micro-instruction in the same clock cycle. Each element owns a small bit-addressed local memory, a data register that also drives its links to its neighbours, an operand register, a carry register and a mask bit. A controller outside the block issues one control word per cycle. The word holds an opcode, a single memory bit address that every element uses, and a topology code that sets how the grid edges connect when data moves between neighbours.

Multi-bit arithmetic runs bit-serially. The controller walks through the operand bits from the least significant bit upwards. Each step goes through the element's full adder, and the carry is kept in the carry register between steps, so operand length is set only by the instruction sequence. A registered global OR of the data bits of all unmasked elements goes back to the controller. This OR lets the controller run bit-serial searches: in a maximum search it walks the bits from the most significant down and narrows the mask at each bit.

A host port reads and writes any single memory bit, selected by row, column and bit address, while no instruction is issued.

Top module: `simd_mesh_array`

## Requirements
- R1: After reset every data, operand and carry register is 0, every mask bit is 1, every local memory bit is 0, and `gor` is 0.
- R2: When `host_we` is 1 and `instr_valid` is 0, the selected memory bit takes `host_wdata` at the clock edge, and `host_rdata` shows the selected bit combinationally. When `instr_valid` is 1, a host write has no effect.
- R3: Opcode 1 copies memory bit `addr` into the data register, and opcode 2 copies it into the operand register. Neither is masked. Opcode 3 writes the data register to memory bit `addr`, but only in elements whose mask is 1. Opcode 0, or `instr_valid` at 0, changes nothing.
- R4: Opcode 4 (masked) replaces the data register with data XOR operand XOR carry, and replaces the carry with the majority of the three. Opcode 5 (masked) clears the carry. Adding two N-bit operands least significant bit first, then adding two zero bits, gives the (N+1)-bit sum.
- R5: Opcodes 6, 7 and 8 (masked) combine the data register with memory bit `addr` by AND, OR and XOR respectively.
- R6: Opcodes 9, 10, 11 and 12 load each element's data register with the pre-instruction data register of its north (row-1), south (row+1), east (col+1) or west (col-1) neighbour, all elements at once, regardless of mask. With `topo`=0 (plane), sources outside the grid give 0.
- R7: With `topo`=1 (cylinder), east and west sources wrap within the same row, and north and south sources outside the grid give 0.
- R8: With `topo`=2 (chain), the elements form one row-major line: the east source of the last column is column 0 of the next row, the west source of column 0 is the last column of the previous row, the two ends of the line get 0, and north and south behave as on a plane.
- R9: With `topo`=3 (torus), sources wrap in both dimensions.
- R10: Opcode 13 copies the data register into the mask, opcode 14 sets every mask to 1, and opcode 15 ANDs the mask with the data register. None of them is masked.
- R11: `gor` is a register that, one cycle after an instruction, holds the OR over all elements of (data AND mask) after that instruction. With no instruction it keeps its value.
- R12: A maximum search works as follows. Set all masks with opcode 14. Then, for each bit from the most significant down, load that bit with opcode 1 and, when the next `gor` is 1, issue opcode 15. At the end exactly the elements holding the maximum value remain masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | A micro-instruction is issued this cycle |
| op | input | 4 | Opcode |
| addr | input | $clog2(MEM_BITS) | Broadcast memory bit address |
| topo | input | 2 | Edge topology: 0 plane, 1 cylinder, 2 chain, 3 torus |
| host_we | input | 1 | Host write strobe, honoured only when idle |
| host_row | input | $clog2(ROWS) | Host element row |
| host_col | input | $clog2(COLS) | Host element column |
| host_addr | input | $clog2(MEM_BITS) | Host bit address |
| host_wdata | input | 1 | Host write data |
| host_rdata | output | 1 | Selected memory bit |
| gor | output | 1 | Registered global OR of masked data bits |

## Verification
On every cycle, the assertions check that `gor` holds while the array is idle, that a host write while idle reads back at once, that a host write issued alongside an instruction leaves the addressed bit unchanged, and that the outputs are never unknown. The bench's scenarios are the only way to show the arithmetic and data-movement behaviour. These scenarios are a multi-bit vector add with its carry-out bit, masked stores and logic operations, all four neighbour directions under each of the four topologies, and a full maximum search. Each is compared against a behavioural model, and the sums and the search result are also checked against direct integer arithmetic.

// File: rtl/simd_mesh_array.sv
`timescale 1ns/1ps
module simd_mesh_array #(
  parameter int ROWS     = 8,
  parameter int COLS     = 8,
  parameter int MEM_BITS = 32,
  localparam int NPE = ROWS * COLS,
  localparam int AW  = $clog2(MEM_BITS),
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS),
  localparam int IW  = $clog2(NPE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [3:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    topo,
  input  logic          host_we,
  input  logic [RW-1:0] host_row,
  input  logic [CW-1:0] host_col,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wdata,
  output logic          host_rdata,
  output logic          gor
);
  localparam logic [3:0] OP_NOP = 4'd0, OP_LDD = 4'd1, OP_LDA = 4'd2, OP_STO = 4'd3;
  localparam logic [3:0] OP_ADD = 4'd4, OP_CLRC = 4'd5, OP_AND = 4'd6, OP_OR = 4'd7;
  localparam logic [3:0] OP_XOR = 4'd8, OP_FN = 4'd9, OP_FS = 4'd10, OP_FE = 4'd11;
  localparam logic [3:0] OP_FW = 4'd12, OP_SETM = 4'd13, OP_ALLM = 4'd14, OP_MAND = 4'd15;

  logic [NPE-1:0] d_q, a_q, c_q, m_q;
  logic [NPE-1:0] d_n, a_n, c_n, m_n;
  logic [NPE-1:0] mem_bit, rd_bit;
  logic [3:0]     eop;
  logic [IW-1:0]  hidx;
  logic           host_wr, wrap_ew, wrap_ns, chain;

  assign eop     = instr_valid ? op : OP_NOP;
  assign host_wr = host_we & ~instr_valid;
  assign hidx    = IW'(host_row) * IW'(COLS) + IW'(host_col);
  assign wrap_ew = (topo == 2'd1) || (topo == 2'd3);
  assign wrap_ns = (topo == 2'd3);
  assign chain   = (topo == 2'd2);

  function automatic logic [3:0] pe_step(input logic [3:0] o, input logic d, a, c, m, mb,
                                         input logic nn, ns, ne, nw);
    logic nd, na, nc, nm;
    nd = d; na = a; nc = c; nm = m;
    case (o)
      OP_LDD:  nd = mb;
      OP_LDA:  na = mb;
      OP_ADD:  if (m) begin nd = d ^ a ^ c; nc = (d & a) | (d & c) | (a & c); end
      OP_CLRC: if (m) nc = 1'b0;
      OP_AND:  if (m) nd = d & mb;
      OP_OR:   if (m) nd = d | mb;
      OP_XOR:  if (m) nd = d ^ mb;
      OP_FN:   nd = nn;
      OP_FS:   nd = ns;
      OP_FE:   nd = ne;
      OP_FW:   nd = nw;
      OP_SETM: nm = d;
      OP_ALLM: nm = 1'b1;
      OP_MAND: nm = m & d;
      default: ;
    endcase
    return {nd, na, nc, nm};
  endfunction

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int I = r * COLS + c;
      logic nb_n, nb_s, nb_e, nb_w;
      logic [MEM_BITS-1:0] bits;

      if (r > 0) begin : g_n_in
        assign nb_n = d_q[I-COLS];
      end else begin : g_n_edge
        assign nb_n = wrap_ns & d_q[(ROWS-1)*COLS + c];
      end

      if (r < ROWS-1) begin : g_s_in
        assign nb_s = d_q[I+COLS];
      end else begin : g_s_edge
        assign nb_s = wrap_ns & d_q[c];
      end

      if (c < COLS-1) begin : g_e_in
        assign nb_e = d_q[I+1];
      end else if (r < ROWS-1) begin : g_e_chain
        assign nb_e = wrap_ew ? d_q[r*COLS] : (chain & d_q[I+1]);
      end else begin : g_e_end
        assign nb_e = wrap_ew & d_q[r*COLS];
      end

      if (c > 0) begin : g_w_in
        assign nb_w = d_q[I-1];
      end else if (r > 0) begin : g_w_chain
        assign nb_w = wrap_ew ? d_q[r*COLS + COLS-1] : (chain & d_q[I-1]);
      end else begin : g_w_end
        assign nb_w = wrap_ew & d_q[r*COLS + COLS-1];
      end

      assign {d_n[I], a_n[I], c_n[I], m_n[I]} =
        pe_step(eop, d_q[I], a_q[I], c_q[I], m_q[I], mem_bit[I], nb_n, nb_s, nb_e, nb_w);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bits <= '0;
        else if (host_wr && hidx == IW'(I))
          bits[host_addr] <= host_wdata;
        else if (eop == OP_STO && m_q[I])
          bits[addr] <= d_q[I];
      end

      assign mem_bit[I] = bits[addr];
      assign rd_bit[I]  = bits[host_addr];
    end
  end

  assign host_rdata = rd_bit[hidx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
      a_q <= '0;
      c_q <= '0;
      m_q <= '1;
      gor <= 1'b0;
    end else begin
      d_q <= d_n;
      a_q <= a_n;
      c_q <= c_n;
      m_q <= m_n;
      gor <= |(d_n & m_n);
    end
  end
endmodule

// File: rtl/simd_mesh_array_chk.sv
`timescale 1ns/1ps
module simd_mesh_array_chk #(
  parameter int AW = 5,
  parameter int RW = 3,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic [3:0]    op,
  input logic          host_we,
  input logic [RW-1:0] host_row,
  input logic [CW-1:0] host_col,
  input logic [AW-1:0] host_addr,
  input logic          host_wdata,
  input logic          host_rdata,
  input logic          gor
);
  assert_idle_gor_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(gor));

  assert_host_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !instr_valid) |=>
      (!($stable(host_row) && $stable(host_col) && $stable(host_addr)) ||
       host_rdata == $past(host_wdata)));

  assert_busy_host_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && op != 4'd3) |=>
      (!($stable(host_row) && $stable(host_col) && $stable(host_addr)) ||
       $stable(host_rdata)));

  assert_outputs_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({gor, host_rdata}));
endmodule

bind simd_mesh_array simd_mesh_array_chk #(.AW(AW), .RW(RW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .op(op), .host_we(host_we),
  .host_row(host_row), .host_col(host_col), .host_addr(host_addr),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .gor(gor));

// File: tb/simd_mesh_array_bench.sv
`timescale 1ns/1ps
module simd_mesh_array_bench;
  localparam int R = 8, C = 8, MB = 32;
  logic clk = 0, rst_n = 0, instr_valid = 0, host_we = 0, host_wdata = 0;
  logic [3:0] op = 0;
  logic [4:0] addr = 0, host_addr = 0;
  logic [1:0] topo = 0;
  logic [2:0] host_row = 0, host_col = 0;
  logic host_rdata, gor;
  int nchk = 0, nerr = 0;

  bit md[R][C][MB];
  bit rd[R][C], ra[R][C], rc[R][C], rm[R][C], od[R][C];
  bit rgor;
  int av[R][C], bv[R][C];

  simd_mesh_array u_simd_mesh_array (.clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
    .op(op), .addr(addr), .topo(topo), .host_we(host_we), .host_row(host_row),
    .host_col(host_col), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .gor(gor));

  always #2 clk = ~clk;

  task automatic chk(bit act, bit exp, string req, string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  function automatic bit nbv(int r, int c, int dir, int tp);
    int nr = r, nc = c, idx;
    case (dir)
      0: nr = r - 1;
      1: nr = r + 1;
      2: nc = c + 1;
      default: nc = c - 1;
    endcase
    if (dir < 2) begin
      if (nr >= 0 && nr < R) return od[nr][c];
      if (tp == 3) return od[(nr + R) % R][c];
      return 1'b0;
    end
    if (nc >= 0 && nc < C) return od[r][nc];
    if (tp == 1 || tp == 3) return od[r][(nc + C) % C];
    if (tp == 2) begin
      idx = r * C + c + ((dir == 2) ? 1 : -1);
      if (idx >= 0 && idx < R * C) return od[idx / C][idx % C];
    end
    return 1'b0;
  endfunction

  task automatic model_step(int o, int ad, int tp);
    bit mb, en;
    int s;
    od = rd;
    rgor = 0;
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        mb = md[r][c][ad];
        en = rm[r][c];
        case (o)
          1: rd[r][c] = mb;
          2: ra[r][c] = mb;
          3: if (en) md[r][c][ad] = od[r][c];
          4: if (en) begin
               s = int'(od[r][c]) + int'(ra[r][c]) + int'(rc[r][c]);
               rd[r][c] = s[0]; rc[r][c] = s[1];
             end
          5: if (en) rc[r][c] = 0;
          6: if (en) rd[r][c] = od[r][c] & mb;
          7: if (en) rd[r][c] = od[r][c] | mb;
          8: if (en) rd[r][c] = od[r][c] ^ mb;
          9, 10, 11, 12: rd[r][c] = nbv(r, c, o - 9, tp);
          13: rm[r][c] = od[r][c];
          14: rm[r][c] = 1;
          15: rm[r][c] = rm[r][c] & od[r][c];
          default: ;
        endcase
      end
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) rgor |= rd[r][c] & rm[r][c];
  endtask

  task automatic issue(int o, int ad, int tp);
    @(negedge clk);
    instr_valid = 1; op = 4'(o); addr = 5'(ad); topo = 2'(tp);
    @(posedge clk);
    model_step(o, ad, tp);
    @(negedge clk);
    instr_valid = 0; op = 0;
    chk(gor, rgor, "R11", $sformatf("gor after op %0d", o));
  endtask

  task automatic hwrite(int r, int c, int ad, bit v);
    @(negedge clk);
    host_we = 1; host_row = 3'(r); host_col = 3'(c); host_addr = 5'(ad); host_wdata = v;
    @(posedge clk);
    md[r][c][ad] = v;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic cmp_plane(int ad, string req);
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        host_row = 3'(r); host_col = 3'(c); host_addr = 5'(ad);
        #0.5;
        chk(host_rdata, md[r][c][ad], req, $sformatf("mem[%0d][%0d] bit %0d", r, c, ad));
      end
  endtask

  task automatic run_all;
    int mx, got;
    bit keep;
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        rd[r][c] = 0; ra[r][c] = 0; rc[r][c] = 0; rm[r][c] = 1;
        for (int k = 0; k < MB; k++) md[r][c][k] = 0;
      end
    rgor = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(gor, 1'b0, "R1", "gor after reset");
    cmp_plane(0, "R1");
    cmp_plane(31, "R1");

    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        av[r][c] = (r * 3 + c * 5 + 1) % 16;
        bv[r][c] = (r * 7 + c * 2 + 3) % 16;
        if (r == 5 && c == 2) av[r][c] = 15;
        for (int k = 0; k < 4; k++) begin
          hwrite(r, c, k, av[r][c][k]);
          hwrite(r, c, 4 + k, bv[r][c][k]);
        end
        hwrite(r, c, 21, 1'b1);
        hwrite(r, c, 20, 1'((r + c) & 1));
        hwrite(r, c, 24, 1'(((r * C + c) * 7) % 5 == 0));
      end
    for (int k = 0; k < 8; k++) cmp_plane(k, "R2");

    @(negedge clk);
    instr_valid = 1; op = 0; host_we = 1; host_row = 3; host_col = 4; host_addr = 0;
    host_wdata = ~md[3][4][0];
    @(negedge clk);
    instr_valid = 0; host_we = 0;
    #0.5;
    chk(host_rdata, md[3][4][0], "R2", "host write while busy ignored");

    issue(5, 0, 0);
    for (int k = 0; k < 4; k++) begin
      issue(1, k, 0); issue(2, 4 + k, 0); issue(4, 0, 0); issue(3, 8 + k, 0);
    end
    issue(1, 31, 0); issue(2, 31, 0); issue(4, 0, 0); issue(3, 12, 0);
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        got = 0;
        for (int k = 0; k < 5; k++) begin
          host_row = 3'(r); host_col = 3'(c); host_addr = 5'(8 + k);
          #0.5;
          got[k] = host_rdata;
        end
        nchk++;
        if (got != av[r][c] + bv[r][c]) begin
          nerr++;
          $display("FAIL R4 sum[%0d][%0d] actual=%0d expected=%0d", r, c, got, av[r][c] + bv[r][c]);
        end
      end

    issue(1, 20, 0); issue(13, 0, 0);
    issue(1, 21, 0); issue(3, 22, 0);
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        host_row = 3'(r); host_col = 3'(c); host_addr = 22;
        #0.5;
        chk(host_rdata, 1'((r + c) & 1), "R3", $sformatf("masked store [%0d][%0d]", r, c));
      end
    issue(1, 24, 0); issue(8, 0, 0); issue(3, 23, 0);
    cmp_plane(23, "R5");
    issue(14, 0, 0);
    issue(1, 24, 0); issue(7, 1, 0); issue(3, 27, 0);
    issue(1, 24, 0); issue(6, 2, 0); issue(3, 28, 0);
    cmp_plane(27, "R5");
    cmp_plane(28, "R5");

    for (int tp = 0; tp < 4; tp++)
      for (int dir = 0; dir < 4; dir++) begin
        issue(1, 24, tp); issue(9 + dir, 0, tp); issue(3, 25, tp);
        case (tp)
          0: cmp_plane(25, "R6");
          1: cmp_plane(25, "R7");
          2: cmp_plane(25, "R8");
          default: cmp_plane(25, "R9");
        endcase
      end

    issue(14, 0, 0);
    for (int k = 3; k >= 0; k--) begin
      issue(1, k, 0);
      keep = rgor;
      if (keep) issue(15, 0, 0);
    end
    issue(1, 21, 0);
    chk(gor, 1'b1, "R10", "some element stays masked");
    issue(3, 26, 0);
    mx = 0;
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) if (av[r][c] > mx) mx = av[r][c];
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        host_row = 3'(r); host_col = 3'(c); host_addr = 26;
        #0.5;
        chk(host_rdata, 1'(av[r][c] == mx), "R12", $sformatf("max flag [%0d][%0d]", r, c));
      end
    repeat (3) @(negedge clk);
    chk(gor, rgor, "R11", "gor held while idle");
  endtask

  initial begin
    run_all;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule